// File: doc/BRIEF.md
# Serial Audio Bit-Clock and Frame-Sync Generator

This block is the timing master of a serial audio port. From one reference clock it makes a bit-clock, given both as a one-cycle enable pulse and as a square-ish level, by dividing the reference by a programmable ratio. It then counts bit-clocks to form a frame-sync whose period and high width are each programmed in bit-clocks. All three counts are written as the wanted value minus one. For example, a divider of 3 against a 256fs master gives a 64fs bit-clock, and a period of 63 with a width of 31 gives a sync that is high for one 32-bit phase and low for the other.

Two controls start the block. A generator enable starts the divider, but only once it has been held low for at least two reference cycles. A separate frame enable starts frame counting on the next bit-clock boundary. A transmit sync output either follows the generator sync directly (free mode) or passes it only for frames that a transmit-data write preceded (gated mode).

Top module: `serial_rate_gen`

## Requirements
- R1: While rst_n is low, and on the cycle after it was sampled low, bclk_en, bclk_lvl, fsync and fsx are all 0.
- R2: The generator starts only when gen_en is sampled high after it has been sampled low on at least two consecutive cycles (reset counts as such a hold). A single low cycle stops the generator and leaves it stopped, with no bclk_en, until a proper two-cycle hold has been seen. After a valid release, bclk_en is 1 on the first cycle after gen_en was sampled high.
- R3: While running, bclk_en pulses once every div_m1+1 reference cycles. div_m1 = 0 gives a pulse on every cycle.
- R4: bclk_lvl rises on the bclk_en cycle and stays high for floor(div_m1/2)+1 cycles, then is low for the rest of the bit period. With div_m1 = 0 it is constantly high.
- R5: Frame bits are counted in bclk_en cycles. Bit 0 of a new frame recurs every per_m1+1 bits.
- R6: fsync is high for frame bits 0 to wid_m1 and low for the rest. When wid_m1 ≥ per_m1, fsync stays high.
- R7: While gen_en and fs_en stay high, fsync changes only on a cycle in which bclk_en is 1 (the bit-clock rising edge).
- R8: fsync is 0 on the cycle after fs_en was sampled low, and the bit-clock keeps running. If fs_en is high at release, frame bit 0 is the first running cycle. Otherwise, frame bit 0 is the first bclk_en cycle after the cycle in which fs_en was raised.
- R9: With sync_free = 1, fsx equals fsync. With sync_free = 0, fsx equals fsync during a frame only if a tx_wr pulse was sampled after the start of the previous frame and no later than the cycle before the new frame's bit 0. Otherwise fsx is 0 for that frame. fsx is never high while fsync is low.
- R10: On the cycle after gen_en is sampled low, bclk_en, bclk_lvl, fsync and fsx are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_en | input | 1 | Generator enable; needs a two-cycle low hold before it takes effect |
| fs_en | input | 1 | Frame-sync counting enable |
| div_m1 | input | DIV_W | Bit-clock divide ratio minus one |
| per_m1 | input | PER_W | Frame period in bit-clocks minus one |
| wid_m1 | input | WID_W | Frame-sync high width in bit-clocks minus one |
| sync_free | input | 1 | 1: fsx follows fsync; 0: fsx gated by data writes |
| tx_wr | input | 1 | Transmit-data write strobe, one cycle |
| bclk_en | output | 1 | One-cycle pulse at each bit-clock rising edge |
| bclk_lvl | output | 1 | Bit-clock level |
| fsync | output | 1 | Generator frame-sync level |
| fsx | output | 1 | Transmit frame-sync level |

## Verification
On every cycle the assertions check four things: the spacing of bit-clock pulses against the divider, that bclk_lvl is high at each pulse, that fsync moves only on bit-clock edges, and the immediate silencing after gen_en or fs_en drops. They also check that fsx never leads fsync and that it copies fsync in free mode. Several behaviours can only be shown by the bench's scenarios, because they depend on what the stimulus did earlier: the high-time of bclk_lvl, the bit-exact frame pattern including width ≥ period, and the two-cycle release rule. The same holds for where frame bit 0 lands after fs_en rises and for which frames a write arms in gated mode.

// File: rtl/srg_pkg.sv
// Package: shared types and constants of the bit-clock / frame-sync generator.
package srg_pkg;

    // Transmit frame-sync selection.
    typedef enum logic {
        SYNC_GATED = 1'b0,
        SYNC_FREE  = 1'b1
    } sync_sel_e;

    // Reference cycles gen_en must be held low before a release is honoured.
    localparam int unsigned SRG_HOLD_CYC = 2;

endpackage

// File: rtl/srg_release.sv
// Module: srg_release
// Decides when the generator runs. A release (gen_en high) is honoured only
// after gen_en has been sampled low on HOLD_CYC consecutive cycles; reset
// counts as a complete hold. Dropping gen_en stops the generator at once.
// Assumes: gen_en is synchronous to clk.
module srg_release #(
    parameter int unsigned HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gen_en,
    output logic run,
    output logic launch
);

    localparam int unsigned HOLD_W = $clog2(HOLD_CYC + 1);
    localparam logic [HOLD_W-1:0] HOLD_FULL = HOLD_W'(HOLD_CYC);

    logic [HOLD_W-1:0] hold_cnt;
    logic              run_q;
    logic              hold_done;

    assign hold_done = (hold_cnt == HOLD_FULL);
    // First edge of a valid release: run rises on the following cycle.
    assign launch    = gen_en && !run_q && hold_done;
    assign run       = run_q;

    // Count consecutive low cycles of gen_en, saturating at the full hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= HOLD_FULL;
        end else if (gen_en) begin
            hold_cnt <= '0;
        end else if (!hold_done) begin
            hold_cnt <= hold_cnt + HOLD_W'(1);
        end
    end

    // Run flag: set by a valid release, cleared whenever gen_en is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else begin
            run_q <= gen_en && (run_q || hold_done);
        end
    end

endmodule

// File: rtl/srg_clkdiv.sv
// Module: srg_clkdiv
// Divides the reference clock by div_m1+1 to form the bit-clock. bclk_en
// marks the first reference cycle of each bit period (the rising edge);
// bit_end marks the last. The level is high for the first half, rounded up.
// Assumes: div_m1 is changed only while run is low.
module srg_clkdiv #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_m1,
    output logic             bclk_en,
    output logic             bclk_lvl,
    output logic             bit_end
);

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] half_m1;

    assign half_m1  = div_m1 >> 1;
    assign bclk_en  = run && (div_cnt == '0);
    assign bclk_lvl = run && (div_cnt <= half_m1);
    assign bit_end  = run && (div_cnt >= div_m1);

    // Reference-cycle position inside the current bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt <= '0;
        end else if (div_cnt >= div_m1) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/srg_framer.sv
// Module: srg_framer
// Counts bit-clocks into frames of per_m1+1 bits and drives the frame-sync
// high for bits 0..wid_m1. Counting starts on release (when fs_en is already
// high) or at the next bit boundary after fs_en rises; fs_en low clears it.
// frame_start flags the clock edge that makes the next cycle frame bit 0.
// Assumes: per_m1 and wid_m1 change only while the generator is stopped.
module srg_framer #(
    parameter int unsigned PER_W = 12,
    parameter int unsigned WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             launch,
    input  logic             bit_end,
    input  logic             fs_en,
    input  logic [PER_W-1:0] per_m1,
    input  logic [WID_W-1:0] wid_m1,
    output logic             fsync,
    output logic             frame_start
);

    localparam int unsigned CMP_W = (PER_W > WID_W) ? PER_W : WID_W;

    logic             fs_live;
    logic [PER_W-1:0] frm_cnt;
    logic [CMP_W-1:0] cnt_x;
    logic [CMP_W-1:0] wid_x;
    logic             last_bit;

    assign cnt_x    = CMP_W'(frm_cnt);
    assign wid_x    = CMP_W'(wid_m1);
    assign last_bit = (frm_cnt >= per_m1);
    assign fsync    = run && fs_live && (cnt_x <= wid_x);

    // Edge that makes the following cycle frame bit 0.
    always_comb begin
        if (launch) begin
            frame_start = fs_en;
        end else if (run && fs_en && bit_end) begin
            frame_start = !fs_live || last_bit;
        end else begin
            frame_start = 1'b0;
        end
    end

    // Frame-counting state: live flag and bit position in the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_live <= 1'b0;
            frm_cnt <= '0;
        end else if (launch) begin
            fs_live <= fs_en;
            frm_cnt <= '0;
        end else if (!run || !fs_en) begin
            fs_live <= 1'b0;
            frm_cnt <= '0;
        end else if (bit_end) begin
            fs_live <= 1'b1;
            if (!fs_live || last_bit) begin
                frm_cnt <= '0;
            end else begin
                frm_cnt <= frm_cnt + PER_W'(1);
            end
        end
    end

endmodule

// File: rtl/srg_txsync.sv
// Module: srg_txsync
// Forms the transmit frame-sync. In free mode it is the generator sync. In
// gated mode a frame is armed at its start only if a data write was seen
// since the previous frame start (a write on the start edge itself counts).
// Assumes: tx_wr is a one-cycle strobe synchronous to clk.
module srg_txsync
    import srg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      frame_start,
    input  logic      tx_wr,
    input  sync_sel_e sel,
    input  logic      fsync,
    output logic      fsx
);

    logic wr_pend;
    logic armed;

    // Remember writes and arm or disarm each frame at its start edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pend <= 1'b0;
            armed   <= 1'b0;
        end else if (frame_start) begin
            armed   <= wr_pend || tx_wr;
            wr_pend <= 1'b0;
        end else if (!run) begin
            armed   <= 1'b0;
            wr_pend <= 1'b0;
        end else begin
            wr_pend <= wr_pend || tx_wr;
        end
    end

    // Output select between direct and write-gated sync.
    always_comb begin
        if (sel == SYNC_FREE) begin
            fsx = fsync;
        end else begin
            fsx = fsync && armed;
        end
    end

endmodule

// File: rtl/serial_rate_gen.sv
// Module: serial_rate_gen (top)
// Master-mode bit-clock and frame-sync generator for a serial audio port.
// It chains the release qualifier, the divider, the framer and the transmit
// sync selector. All counts are programmed as value minus one.
// Assumes: the count fields are stable while gen_en is high.
module serial_rate_gen
    import srg_pkg::*;
#(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned PER_W = 12,
    parameter int unsigned WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             fs_en,
    input  logic [DIV_W-1:0] div_m1,
    input  logic [PER_W-1:0] per_m1,
    input  logic [WID_W-1:0] wid_m1,
    input  logic             sync_free,
    input  logic             tx_wr,
    output logic             bclk_en,
    output logic             bclk_lvl,
    output logic             fsync,
    output logic             fsx
);

    logic      run;
    logic      launch;
    logic      bit_end;
    logic      frame_start;
    sync_sel_e sel;

    assign sel = sync_sel_e'(sync_free);

    srg_release #(.HOLD_CYC(SRG_HOLD_CYC)) u_release (
        .clk    (clk),
        .rst_n  (rst_n),
        .gen_en (gen_en),
        .run    (run),
        .launch (launch)
    );

    srg_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div_m1   (div_m1),
        .bclk_en  (bclk_en),
        .bclk_lvl (bclk_lvl),
        .bit_end  (bit_end)
    );

    srg_framer #(.PER_W(PER_W), .WID_W(WID_W)) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .launch      (launch),
        .bit_end     (bit_end),
        .fs_en       (fs_en),
        .per_m1      (per_m1),
        .wid_m1      (wid_m1),
        .fsync       (fsync),
        .frame_start (frame_start)
    );

    srg_txsync u_txsync (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .frame_start (frame_start),
        .tx_wr       (tx_wr),
        .sel         (sel),
        .fsync       (fsync),
        .fsx         (fsx)
    );

endmodule

// File: rtl/serial_rate_gen_chk.sv
// Module: serial_rate_gen_chk
// Property checker bound to serial_rate_gen; observes its ports only.
module serial_rate_gen_chk #(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned PER_W = 12,
    parameter int unsigned WID_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gen_en,
    input logic             fs_en,
    input logic [DIV_W-1:0] div_m1,
    input logic [PER_W-1:0] per_m1,
    input logic [WID_W-1:0] wid_m1,
    input logic             sync_free,
    input logic             tx_wr,
    input logic             bclk_en,
    input logic             bclk_lvl,
    input logic             fsync,
    input logic             fsx
);

    localparam int unsigned GAP_W = DIV_W + 1;

    logic [GAP_W-1:0] gap;
    logic             seen;

    // Cycles since the last bit-clock pulse of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n || !gen_en) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (bclk_en) begin
            gap  <= GAP_W'(1);
            seen <= 1'b1;
        end else if (gap != {GAP_W{1'b1}}) begin
            gap <= gap + GAP_W'(1);
        end
    end

    assert_bclk_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_en && seen && gen_en && $stable(div_m1)) |-> (gap == (GAP_W'(div_m1) + GAP_W'(1))));

    assert_lvl_high_at_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_en |-> bclk_lvl);

    assert_sync_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gen_en) && gen_en && $past(fs_en) && fs_en && (fsync != $past(fsync))) |-> bclk_en);

    assert_fs_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fs_en) |-> !fsync);

    assert_fsx_within_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fsx |-> fsync);

    assert_free_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_free |-> (fsx == fsync));

    assert_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(gen_en) |-> (!bclk_en && !bclk_lvl && !fsync && !fsx));

    // Inputs observed for completeness of the bound port set.
    logic unused_ok;
    assign unused_ok = ^{per_m1, wid_m1, tx_wr};

endmodule

bind serial_rate_gen serial_rate_gen_chk #(
    .DIV_W(DIV_W),
    .PER_W(PER_W),
    .WID_W(WID_W)
) u_chk (.*);

// File: tb/tb_serial_rate_gen.sv
`timescale 1ns/1ps
module tb_serial_rate_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_en = 1'b0;
    logic        fs_en = 1'b0;
    logic [7:0]  div_m1 = '0;
    logic [11:0] per_m1 = '0;
    logic [7:0]  wid_m1 = '0;
    logic        sync_free = 1'b1;
    logic        tx_wr = 1'b0;
    logic        bclk_en, bclk_lvl, fsync, fsx;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    serial_rate_gen dut (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .fs_en(fs_en),
        .div_m1(div_m1), .per_m1(per_m1), .wid_m1(wid_m1),
        .sync_free(sync_free), .tx_wr(tx_wr),
        .bclk_en(bclk_en), .bclk_lvl(bclk_lvl), .fsync(fsync), .fsx(fsx)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int outs();
        return {28'd0, bclk_en, bclk_lvl, fsync, fsx};
    endfunction

    // Stop, hold low, program, release; returns on the first running cycle.
    task automatic restart(input int dv, input int pv, input int wv, input bit fs, input bit md);
        gen_en = 1'b0;
        repeat (3) tick();
        div_m1 = dv[7:0];
        per_m1 = pv[11:0];
        wid_m1 = wv[7:0];
        fs_en = fs;
        sync_free = md;
        gen_en = 1'b1;
        tick();
    endtask

    // Compare fsync at each bit-clock edge with the programmed frame pattern.
    task automatic frame_bits(input int pv, input int wv, input int nbits, output int errs);
        errs = 0;
        for (int b = 0; b < nbits; b++) begin
            int guard = 0;
            while (!bclk_en && guard < 600) begin tick(); guard++; end
            if (fsync != ((b % (pv + 1)) <= wv)) errs++;
            tick();
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        gen_en = 1'b1;
        fs_en = 1'b1;
        repeat (3) tick();
        check(outs() == 0, "R1 outputs in reset", outs(), 0);
        gen_en = 1'b0;
        rst_n = 1'b1;
        begin
            int act = 0;
            for (int i = 0; i < 10; i++) begin act |= outs(); tick(); end
            check(act == 0, "R10 idle after reset with gen_en low", act, 0);
        end
        restart(1, 7, 3, 1, 1);
        repeat (5) tick();
        rst_n = 1'b0;
        tick();
        check(outs() == 0, "R1 reset while running", outs(), 0);
        rst_n = 1'b1;
        gen_en = 1'b0;
        tick();
    endtask

    task automatic t_divider(input int dv);
        int n = 0;
        int hi = 0;
        restart(dv, 63, 31, 0, 1);
        check(bclk_en == 1'b1, "R2 first pulse after release", bclk_en, 1);
        do begin
            hi += bclk_lvl;
            n++;
            tick();
        end while (!bclk_en && n < 300);
        check(n == dv + 1, "R3 bit period", n, dv + 1);
        check(hi == dv / 2 + 1, "R4 level high time", hi, dv / 2 + 1);
    endtask

    task automatic t_frame(input int dv, input int pv, input int wv);
        int errs;
        restart(dv, pv, wv, 1, 1);
        check(fsync == 1'b1, "R8 bit 0 at release", fsync, 1);
        frame_bits(pv, wv, 2 * (pv + 1), errs);
        check(errs == 0, "R5 R6 frame pattern", errs, 0);
    endtask

    task automatic t_fsen();
        int hi = 0;
        int pulses = 0;
        int errs;
        restart(1, 5, 1, 0, 1);
        for (int i = 0; i < 20; i++) begin
            hi += fsync;
            pulses += bclk_en;
            tick();
        end
        check(hi == 0, "R8 no sync while fs_en low", hi, 0);
        check(pulses == 10, "R3 bit clock runs while fs_en low", pulses, 10);
        fs_en = 1'b1;
        tick();
        frame_bits(5, 1, 12, errs);
        check(errs == 0, "R8 frame starts at next edge", errs, 0);
        fs_en = 1'b0;
        tick();
        check(fsync == 1'b0, "R8 sync off after fs_en low", fsync, 0);
    endtask

    task automatic t_release();
        int pulses = 0;
        restart(2, 7, 3, 1, 1);
        repeat (10) tick();
        gen_en = 1'b0;
        tick();
        check(outs() == 0, "R10 stop after gen_en low", outs(), 0);
        gen_en = 1'b1;
        for (int i = 0; i < 40; i++) begin
            pulses += bclk_en;
            tick();
        end
        check(pulses == 0, "R2 short hold ignored", pulses, 0);
        gen_en = 1'b0;
        tick();
        tick();
        gen_en = 1'b1;
        tick();
        check(bclk_en == 1'b1, "R2 start after two-cycle hold", bclk_en, 1);
    endtask

    task automatic t_gated();
        int errs = 0;
        int ferrs;
        restart(1, 7, 3, 1, 0);
        for (int f = 0; f < 5; f++) begin
            for (int b = 0; b < 8; b++) begin
                int guard = 0;
                bit armed;
                while (!bclk_en && guard < 100) begin tick(); guard++; end
                armed = (f == 1) || (f == 3);
                if (fsx != (armed && (b <= 3))) errs++;
                if (b == 1 && (f == 0 || f == 2)) begin
                    tx_wr = 1'b1;
                    tick();
                    tx_wr = 1'b0;
                end else begin
                    tick();
                end
            end
        end
        check(errs == 0, "R9 gated frames follow writes", errs, 0);
        sync_free = 1'b1;
        ferrs = 0;
        for (int i = 0; i < 40; i++) begin
            if (fsx != fsync) ferrs++;
            tick();
        end
        check(ferrs == 0, "R9 free mode follows sync", ferrs, 0);
    endtask

    initial begin
        tick();
        t_reset();
        t_divider(31);
        t_divider(3);
        t_divider(2);
        t_divider(0);
        t_frame(3, 63, 31);
        t_frame(1, 7, 0);
        t_frame(0, 4, 9);
        t_frame(2, 5, 2);
        t_fsen();
        t_release();
        t_gated();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule